// File: doc/BRIEF.md
# Pad Output Source Selector

This block is a register-programmed crossbar that sits in front of 64 pad drivers. For every pad it holds two selector fields. One selector chooses which internal signal sets the pad's active-low drive enable. The other chooses which internal signal sets the value the pad drives. Selector codes 0 and 1 are reserved for fixed levels. Any higher code picks that bit number out of a peripheral signal bus.

The selectors are packed four pads to a 32-bit word, one byte lane per pad, in two banks. The drive-enable bank starts at byte offset 0x00. The drive-value bank starts at byte offset 0x40. Software updates one pad's lane with a strobed write, so the other three pads in the same word are left untouched. Reads return the selector word for the current address in the same cycle.

Top module: `pad_out_selector`

## Requirements
- R1: After synchronous reset every drive-enable selector holds 1 and every drive-value selector holds 0. Every pad therefore shows padOeN=1 and padOut=0, and both banks read back 32'h01010101 and 32'h00000000 respectively.
- R2: Pad n's drive-enable selector lives in bits [8*(n%4)+5 : 8*(n%4)] of the word at byte address 4*(n/4). Its drive-value selector lives in bits [8*(n%4)+6 : 8*(n%4)] of the word at byte address 0x40 + 4*(n/4).
- R3: A write updates only the byte lanes whose strobe bit regBe[k] is 1, where lane k is bits [8k+7:8k]. Lanes with the strobe at 0 keep their previous selector.
- R4: Unused bits of a lane read as 0 and are not stored by writes. These are bits 7:6 in the drive-enable bank and bit 7 in the drive-value bank.
- R5: Addresses at 0x80 and above read as 0, and writes to them change no selector. Address bits 1:0 are ignored.
- R6: A drive-enable selector of 0 gives padOeN=0, meaning the pad drives. A selector of 1 gives padOeN=1, meaning the pad is an input. Any code s of 2 or more gives padOeN=oeBus[s].
- R7: A drive-value selector of 0 gives padOut=0 and a selector of 1 gives padOut=1. Any code s of 2 or more gives padOut=doBus[s].
- R8: A selector write takes effect at the clock edge that samples it. Pad outputs follow oeBus and doBus combinationally, without a clock delay.
- R9: regRdata is a combinational function of regAddr and the stored selectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write request |
| regAddr | input | 8 | Byte address |
| regWdata | input | 32 | Write data |
| regBe | input | 4 | Byte-lane write strobes |
| regRdata | output | 32 | Read data for regAddr |
| oeBus | input | 64 | Peripheral drive-enable sources |
| doBus | input | 128 | Peripheral drive-value sources |
| padOut | output | 64 | Value to each pad driver |
| padOeN | output | 64 | Active-low drive enable to each pad |

## Verification
The properties assume that regAddr, regWrEn, regWdata and regBe carry defined values at every sampled edge once reset is released. The stimulus meets this by driving every input from time zero and changing inputs only on falling edges. The readback-stability property also assumes that the stored selectors change only through regWrEn. The bench respects this by leaving regWrEn low between writes, and by mixing word-aligned and misaligned addresses, including addresses past both banks.

// File: rtl/pad_sel_pkg.sv
package pad_sel_pkg;
  typedef struct packed {
    logic       wrOe;
    logic       wrDo;
    logic       rdOe;
    logic       rdDo;
    logic [3:0] lane;
  } selCtrl_t;
endpackage

// File: rtl/pad_sel_ctrl.sv
module pad_sel_ctrl
  import pad_sel_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int ADDR_W   = 8,
  parameter int DO_BASE  = 'h40,
  localparam int WORDS   = NUM_PADS / 4,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int BANK_B  = WORDS * 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regBe,
  output selCtrl_t          ctrl,
  output logic [WIDX_W-1:0] wordIdx
);
  localparam logic [ADDR_W:0] OE_END  = (ADDR_W+1)'(BANK_B);
  localparam logic [ADDR_W:0] DO_LO   = (ADDR_W+1)'(DO_BASE);
  localparam logic [ADDR_W:0] DO_END  = (ADDR_W+1)'(DO_BASE + BANK_B);

  logic [ADDR_W:0]   addrExt;
  logic [ADDR_W:0]   offs;
  logic              oeHit;
  logic              doHit;

  always_comb begin
    addrExt = {1'b0, regAddr};
    oeHit   = addrExt < OE_END;
    doHit   = (addrExt >= DO_LO) && (addrExt < DO_END);
    offs    = oeHit ? addrExt : (addrExt - DO_LO);
    wordIdx = offs[WIDX_W+1:2];
    ctrl.rdOe = oeHit;
    ctrl.rdDo = doHit;
    ctrl.wrOe = oeHit && regWrEn;
    ctrl.wrDo = doHit && regWrEn;
    ctrl.lane = regBe;
  end
endmodule

// File: rtl/pad_sel_datapath.sv
module pad_sel_datapath
  import pad_sel_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int OE_SEL_W = 6,
  parameter int DO_SEL_W = 7,
  localparam int WORDS   = NUM_PADS / 4,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int OE_BUS_W = 1 << OE_SEL_W,
  localparam int DO_BUS_W = 1 << DO_SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  selCtrl_t            ctrl,
  input  logic [WIDX_W-1:0]   wordIdx,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [OE_BUS_W-1:0] oeBus,
  input  logic [DO_BUS_W-1:0] doBus,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOeN
);
  logic [31:0] oeWords [WORDS];
  logic [31:0] doWords [WORDS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int W = p / 4;
    localparam int L = p % 4;
    logic [OE_SEL_W-1:0] oeSelQ;
    logic [DO_SEL_W-1:0] doSelQ;
    logic                hitW;

    assign hitW = (wordIdx == WIDX_W'(W)) && ctrl.lane[L];

    always_ff @(posedge clk) begin
      if (rst) begin
        oeSelQ <= OE_SEL_W'(1);
        doSelQ <= '0;
      end else begin
        if (ctrl.wrOe && hitW) oeSelQ <= regWdata[8*L +: OE_SEL_W];
        if (ctrl.wrDo && hitW) doSelQ <= regWdata[8*L +: DO_SEL_W];
      end
    end

    always_comb begin
      unique case (oeSelQ)
        OE_SEL_W'(0): padOeN[p] = 1'b0;
        OE_SEL_W'(1): padOeN[p] = 1'b1;
        default:      padOeN[p] = oeBus[oeSelQ];
      endcase
      unique case (doSelQ)
        DO_SEL_W'(0): padOut[p] = 1'b0;
        DO_SEL_W'(1): padOut[p] = 1'b1;
        default:      padOut[p] = doBus[doSelQ];
      endcase
    end

    assign oeWords[W][8*L +: 8] = 8'(oeSelQ);
    assign doWords[W][8*L +: 8] = 8'(doSelQ);
  end

  always_comb begin
    if (ctrl.rdOe)      regRdata = oeWords[wordIdx];
    else if (ctrl.rdDo) regRdata = doWords[wordIdx];
    else                regRdata = '0;
  end
endmodule

// File: rtl/pad_out_selector.sv
module pad_out_selector
  import pad_sel_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int ADDR_W   = 8,
  parameter int DO_BASE  = 'h40,
  parameter int OE_SEL_W = 6,
  parameter int DO_SEL_W = 7,
  localparam int WIDX_W  = $clog2(NUM_PADS / 4),
  localparam int OE_BUS_W = 1 << OE_SEL_W,
  localparam int DO_BUS_W = 1 << DO_SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  input  logic [3:0]          regBe,
  output logic [31:0]         regRdata,
  input  logic [OE_BUS_W-1:0] oeBus,
  input  logic [DO_BUS_W-1:0] doBus,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOeN
);
  selCtrl_t          ctrl;
  logic [WIDX_W-1:0] wordIdx;

  pad_sel_ctrl #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .DO_BASE(DO_BASE)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regBe(regBe),
    .ctrl(ctrl), .wordIdx(wordIdx)
  );

  pad_sel_datapath #(.NUM_PADS(NUM_PADS), .OE_SEL_W(OE_SEL_W), .DO_SEL_W(DO_SEL_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .wordIdx(wordIdx),
    .regWdata(regWdata), .regRdata(regRdata),
    .oeBus(oeBus), .doBus(doBus), .padOut(padOut), .padOeN(padOeN)
  );
endmodule

// File: rtl/pad_sel_chk.sv
module pad_sel_chk (
  input logic         clk,
  input logic         rst,
  input logic         regWrEn,
  input logic [7:0]   regAddr,
  input logic [31:0]  regWdata,
  input logic [3:0]   regBe,
  input logic [31:0]  regRdata,
  input logic [63:0]  padOut,
  input logic [63:0]  padOeN
);
  // R4
  oe_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr < 8'h40) |-> ((regRdata & 32'hC0C0C0C0) == 32'h0));

  // R4
  do_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr >= 8'h40 && regAddr < 8'h80) |-> ((regRdata & 32'h80808080) == 32'h0));

  // R5
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr >= 8'h80) |-> (regRdata == 32'h0));

  // R9
  readback_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!regWrEn) && $stable(regAddr)) |-> $stable(regRdata));

  // R3
  masked_lane_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !regBe[0]) |=> ((regAddr != $past(regAddr)) ||
                                (regRdata[7:0] == $past(regRdata[7:0]))));

  // R7
  fixed_low_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr[7:2] == 6'h10 && regBe[0] && regWdata[6:0] == 7'd0) |=> !padOut[0]);

  // R6
  fixed_input_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr[7:2] == 6'h00 && regBe[0] && regWdata[5:0] == 6'd1) |=> padOeN[0]);
endmodule

bind pad_out_selector pad_sel_chk u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
  .regBe(regBe), .regRdata(regRdata), .padOut(padOut), .padOeN(padOeN)
);

// File: tb/tb_pad_out_selector.sv
module tb_pad_out_selector;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         regWrEn = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [3:0]   regBe = '0;
  logic [31:0]  regRdata;
  logic [63:0]  oeBus = '0;
  logic [127:0] doBus = '0;
  logic [63:0]  padOut;
  logic [63:0]  padOeN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0] mOe [64];
  logic [6:0] mDo [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_out_selector dut (.*);

  function automatic logic [31:0] expRd(input logic [7:0] a);
    logic [31:0] r = '0;
    int w = a[7:2];
    if (a < 8'h40) for (int l = 0; l < 4; l++) r[8*l +: 8] = {2'b0, mOe[w*4+l]};
    else if (a < 8'h80) for (int l = 0; l < 4; l++) r[8*l +: 8] = {1'b0, mDo[(w-16)*4+l]};
    return r;
  endfunction

  function automatic logic [63:0] expOeN();
    logic [63:0] v;
    for (int p = 0; p < 64; p++)
      v[p] = (mOe[p] == 0) ? 1'b0 : (mOe[p] == 1) ? 1'b1 : oeBus[mOe[p]];
    return v;
  endfunction

  function automatic logic [63:0] expOut();
    logic [63:0] v;
    for (int p = 0; p < 64; p++)
      v[p] = (mDo[p] == 0) ? 1'b0 : (mDo[p] == 1) ? 1'b1 : doBus[mDo[p]];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    int w = a[7:2];
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        if (a < 8'h40) mOe[w*4+l] = d[8*l +: 6];
        else if (a < 8'h80) mDo[(w-16)*4+l] = d[8*l +: 7];
      end
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d; regBe = be;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d, be);
  endtask

  task automatic readCheck(input string req, input logic [7:0] a);
    regAddr = a;
    #1;
    check(req, 128'(regRdata), 128'(expRd(a)));
  endtask

  task automatic padCheck(input string req);
    #1;
    check({req, " oe"}, 128'(padOeN), 128'(expOeN()));
    check({req, " out"}, 128'(padOut), 128'(expOut()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 64; p++) begin mOe[p] = 6'd1; mDo[p] = 7'd0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", 128'(padOeN), 128'(64'hFFFF_FFFF_FFFF_FFFF));
    check("R1 out", 128'(padOut), 128'(64'h0));
    readCheck("R1", 8'h00);
    check("R1 oe word", 128'(regRdata), 128'(32'h01010101));
    readCheck("R1", 8'h7C);
    check("R1 do word", 128'(regRdata), 128'(32'h0));

    // R2 R6 R7: pad 63 is lane 3 of the last word in each bank
    regWrite(8'h3C, 32'h00_00_00_00, 4'b1000);
    regWrite(8'h7C, 32'h7F_00_00_00, 4'b1000);
    doBus = '0; doBus[127] = 1'b1;
    padCheck("R2 pad63");
    check("R2 pad63 drives", 128'(padOeN[63]), 128'(1'b0));
    check("R7 bit127", 128'(padOut[63]), 128'(1'b1));
    doBus[127] = 1'b0;
    #1 check("R8 bus follow", 128'(padOut[63]), 128'(1'b0));

    // R6 code 2 and 63
    regWrite(8'h00, 32'h00_00_3F_02, 4'b0011);
    oeBus = 64'h8000_0000_0000_0004;
    padCheck("R6 codes");
    check("R6 pad1 bit63", 128'(padOeN[1]), 128'(1'b1));
    oeBus = 64'h0;
    padCheck("R8 oe bus");

    // R7 fixed high
    regWrite(8'h44, 32'h00_01_00_00, 4'b0100);
    padCheck("R7 high");
    check("R7 pad6", 128'(padOut[6]), 128'(1'b1));

    // R3 zero strobes change nothing
    regWrite(8'h04, 32'hFFFF_FFFF, 4'b0000);
    readCheck("R3", 8'h04);
    check("R3 pad4 input", 128'(padOeN[4]), 128'(1'b1));

    // R4 unused bits
    regWrite(8'h08, 32'hFFFF_FFFF, 4'b1111);
    readCheck("R4", 8'h08);
    check("R4 oe mask", 128'(regRdata), 128'(32'h3F3F3F3F));
    regWrite(8'h48, 32'hFFFF_FFFF, 4'b1111);
    readCheck("R4", 8'h48);
    check("R4 do mask", 128'(regRdata), 128'(32'h7F7F7F7F));

    // R5 out of range and misaligned address
    regWrite(8'h80, 32'h0000_0000, 4'b1111);
    readCheck("R5", 8'h80);
    readCheck("R5", 8'h00);
    padCheck("R5 no change");
    regWrite(8'h4B, 32'h0000_0001, 4'b0001);
    readCheck("R5 misaligned", 8'h48);
    check("R5 pad8 high", 128'(padOut[8]), 128'(1'b1));

    // random mix R2 R3 R6 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 39) << 2) | 8'($urandom_range(0, 3));
      regWrite(a, $urandom(), 4'($urandom()));
      oeBus = {$urandom(), $urandom()};
      doBus = {$urandom(), $urandom(), $urandom(), $urandom()};
      padCheck("R2 R3 R6 R7 random");
      readCheck("R9 random", 8'($urandom_range(0, 159)));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule